// File: doc/BRIEF.md
# Signature Byte Region Controller

This block adds a small 64-byte side region next to a byte-wide memory array. An external special-mode flag switches the block into signature mode. In that mode the memory's ordinary address bus is re-read: six of its bits are gathered into a 6-bit index that selects one byte of the side region. The two lowest bytes hold a fixed maker code and part code. The other 62 bytes are free for the user and read as all ones until they are written.

Signature accesses are slower than ordinary ones, and all timing is counted in system clock edges. A read drives data only after its address has been held for a set number of edges. A write needs a stable address for a set number of edges before it starts, and its window must stay open for a set number of edges before it stores. When the flag drops, the block keeps the main array locked out for an exit interval before it signals that normal operation may resume. The main array and the high-voltage detector that raises the flag belong elsewhere.

Top module: `sig_region`

## Requirements
- R1: The region index is {addr[6], addr[5], addr[4], addr[12], addr[11], addr[10]}, most significant bit first. No other address bit changes which byte is selected.
- R2: Index 0 reads 8'h34 and index 1 reads 8'h41.
- R3: After reset, every index from 2 to 63 reads 8'hFF until it is written.
- R4: A read (cs=1, oe=1, we=0 in signature mode) raises dout_en only at the READ_LAT-th clock edge (default 4) at which the same address has been sampled. A change of address drops dout_en at once and restarts the count.
- R5: A write (cs=1, we=1 in signature mode) stores din into the selected user byte at the WRITE_CYC-th edge (default 4) of its window. A later read returns that value.
- R6: The address must have been sampled unchanged for at least SETUP_CYC edges (default 2) before the first edge that samples the write. If it was not, the write is discarded and tim_err is set. tim_err stays set until reset.
- R7: A write window that closes before its WRITE_CYC-th edge is discarded and sets tim_err.
- R8: Writes to index 0 or 1 are ignored, do not change those bytes and do not set tim_err.
- R9: Signature mode starts at the first edge that samples the flag high, and accesses before that edge are not counted. After the flag falls, main_ok stays low for EXIT_CYC cycles (default 4) and rises after the EXIT_CYC-th edge. A flag that rises again during that interval is not seen until main_ok has risen.
- R10: dout_en is low whenever the block is outside signature mode, the flag is low, cs or oe is low, or we is high.
- R11: During and right after reset, dout_en=0, main_ok=1 and tim_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_req | input | 1 | Special-mode flag from the high-voltage detector |
| addr | input | 13 | Memory address bus |
| cs | input | 1 | Chip selected |
| oe | input | 1 | Output enable |
| we | input | 1 | Write strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Output drivers on; low means high impedance |
| main_ok | output | 1 | Main array may operate normally |
| tim_err | output | 1 | Sticky flag for a write that broke the setup or width rule |

## Verification
The bench drives inputs and samples outputs on falling clock edges. This lets it count exactly how many rising edges lie between a stimulus and each result. Read data is due after the fourth rising edge of a held address: the bench checks that it is still off after the third edge and on after the fourth. A stored byte is due after the fourth edge of the write window, and the bench reads it back later through the normal read path. main_ok is checked low after the third edge following the flag's fall and high after the fourth. dout_en and tim_err are combinational or one-register results, so they are checked on the falling edge right after the stimulus or right after the edge that ends the window.

// File: rtl/sig_pkg.sv
// Shared constants, types and the address scramble for the signature region.
// Assumes a 13-bit address bus and byte-wide data.
package sig_pkg;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 6;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int ID_COUNT = 2;
    localparam int USER_N   = DEPTH - ID_COUNT;

    localparam logic [DATA_W-1:0] MAKER_CODE = 8'h34;
    localparam logic [DATA_W-1:0] PART_CODE  = 8'h41;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_SIG  = 2'd1,
        ST_EXIT = 2'd2
    } sig_state_t;

    // Gather the six index bits, most significant first.
    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return {a[6], a[5], a[4], a[12], a[11], a[10]};
    endfunction

    // Fixed identification byte for a low index.
    function automatic logic [DATA_W-1:0] id_byte(input logic [IDX_W-1:0] i);
        return (i == '0) ? MAKER_CODE : PART_CODE;
    endfunction
endpackage

// File: rtl/sig_mode_fsm.sv
// Tracks normal, signature and exit phases.
// Assumes sig_req is already synchronous to clk. EXIT_CYC >= 1.
module sig_mode_fsm
    import sig_pkg::*;
#(
    parameter int EXIT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_req,
    output logic in_sig,
    output logic main_ok
);
    localparam int CNT_W = $clog2(EXIT_CYC + 1);

    sig_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;

    // Phase sequencing with the exit hold-off counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORM;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_NORM: if (sig_req) state_q <= ST_SIG;
                ST_SIG: if (!sig_req) begin
                    state_q <= ST_EXIT;
                    cnt_q   <= '0;
                end
                ST_EXIT: begin
                    if (cnt_q == CNT_W'(EXIT_CYC - 1)) state_q <= ST_NORM;
                    else                                cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_NORM;
            endcase
        end
    end

    assign in_sig  = (state_q == ST_SIG);
    assign main_ok = (state_q == ST_NORM);

    AST_EXIT_FOLLOWS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SIG && !sig_req) |=> (state_q == ST_EXIT)); // R9
    AST_RESUME_FROM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_ok) |-> ($past(state_q) == ST_EXIT)); // R9
endmodule

// File: rtl/sig_access_timer.sv
// Counts edges to apply the stretched read latency, write setup and write width.
// Assumes the address is held for the whole write window. WRITE_CYC >= 2.
module sig_access_timer
    import sig_pkg::*;
#(
    parameter int READ_LAT  = 4,
    parameter int SETUP_CYC = 2,
    parameter int WRITE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sig,
    input  logic              sig_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              oe,
    input  logic              we,
    output logic              rd_valid,
    output logic              wr_commit,
    output logic              tim_err
);
    localparam int RC_W = $clog2(READ_LAT + 1);
    localparam int SC_W = $clog2(SETUP_CYC + 1);
    localparam int WC_W = $clog2(WRITE_CYC + 1);

    logic [ADDR_W-1:0] last_addr_q;
    logic [SC_W-1:0]   stab_q;
    logic [RC_W-1:0]   rcnt_q;
    logic [WC_W-1:0]   wcnt_q;
    logic              wr_prev_q;
    logic              wr_bad_q;
    logic              err_q;

    logic same_addr, rd_cond, wr_cond, wr_start, setup_ok, short_end;

    assign same_addr = (addr == last_addr_q);
    assign rd_cond   = in_sig & sig_req & cs & oe & ~we;
    assign wr_cond   = in_sig & sig_req & cs & we;
    assign wr_start  = wr_cond & ~wr_prev_q;
    assign setup_ok  = same_addr && (stab_q >= SC_W'(SETUP_CYC));
    assign short_end = ~wr_cond & wr_prev_q & ~wr_bad_q & (wcnt_q < WC_W'(WRITE_CYC));

    assign rd_valid  = rd_cond & same_addr & (rcnt_q == RC_W'(READ_LAT));
    assign wr_commit = wr_cond & wr_prev_q & ~wr_bad_q & (wcnt_q == WC_W'(WRITE_CYC - 1));
    assign tim_err   = err_q;

    // Count edges over which the address has held its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            stab_q      <= '0;
        end else begin
            last_addr_q <= addr;
            if (!same_addr)                         stab_q <= SC_W'(1);
            else if (stab_q != SC_W'(SETUP_CYC))    stab_q <= stab_q + 1'b1;
        end
    end

    // Count edges of a read held at one address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '0;
        end else if (!rd_cond) begin
            rcnt_q <= '0;
        end else if (!same_addr || rcnt_q == '0) begin
            rcnt_q <= RC_W'(1);
        end else if (rcnt_q != RC_W'(READ_LAT)) begin
            rcnt_q <= rcnt_q + 1'b1;
        end
    end

    // Track the write window length and whether its setup was met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev_q <= 1'b0;
            wr_bad_q  <= 1'b0;
            wcnt_q    <= '0;
        end else begin
            wr_prev_q <= wr_cond;
            if (wr_start) begin
                wcnt_q   <= WC_W'(1);
                wr_bad_q <= ~setup_ok;
            end else if (wr_cond) begin
                if (wcnt_q != WC_W'(WRITE_CYC)) wcnt_q <= wcnt_q + 1'b1;
            end else begin
                wcnt_q   <= '0;
                wr_bad_q <= 1'b0;
            end
        end
    end

    // Sticky record of any setup or width violation.
    always_ff @(posedge clk) begin
        if (!rst_n)                                err_q <= 1'b0;
        else if ((wr_start & ~setup_ok) | short_end) err_q <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R6
    AST_COMMIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(we) && $past(cs) && $past(addr) == addr)); // R5
endmodule

// File: rtl/sig_store.sv
// Holds the 62 user bytes and returns fixed codes for the low indices.
// Assumes writes arrive as a one-cycle commit pulse with a stable index.
module sig_store
    import sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    logic [USER_N-1:0][DATA_W-1:0] user_q;
    logic                          is_user;
    logic [IDX_W-1:0]              uidx;

    assign is_user = (idx >= IDX_W'(ID_COUNT));
    assign uidx    = idx - IDX_W'(ID_COUNT);

    for (genvar i = 0; i < USER_N; i++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        // One user byte: all ones after reset, loaded on its own commit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         cell_q <= '1;
            else if (wr_commit && is_user && uidx == IDX_W'(i)) cell_q <= din;
        end
        assign user_q[i] = cell_q;
    end

    // Fixed codes below the user space, stored bytes above.
    always_comb begin
        if (is_user) rdata = user_q[uidx];
        else         rdata = id_byte(idx);
    end

    AST_USER_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && is_user) |=> (user_q[$past(uidx)] == $past(din))); // R5
endmodule

// File: rtl/sig_region.sv
// Top of the signature region: mode phases, access timing and byte storage.
// Assumes all inputs are synchronous to clk; the main array sits outside.
module sig_region
    import sig_pkg::*;
#(
    parameter int READ_LAT  = 4,
    parameter int SETUP_CYC = 2,
    parameter int WRITE_CYC = 4,
    parameter int EXIT_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              oe,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              main_ok,
    output logic              tim_err
);
    logic              in_sig;
    logic              rd_valid;
    logic              wr_commit;
    logic [DATA_W-1:0] rdata;

    sig_mode_fsm #(.EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_req (sig_req),
        .in_sig  (in_sig),
        .main_ok (main_ok)
    );

    sig_access_timer #(
        .READ_LAT  (READ_LAT),
        .SETUP_CYC (SETUP_CYC),
        .WRITE_CYC (WRITE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sig    (in_sig),
        .sig_req   (sig_req),
        .addr      (addr),
        .cs        (cs),
        .oe        (oe),
        .we        (we),
        .rd_valid  (rd_valid),
        .wr_commit (wr_commit),
        .tim_err   (tim_err)
    );

    sig_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx_of(addr)),
        .wr_commit (wr_commit),
        .din       (din),
        .rdata     (rdata)
    );

    assign dout_en = rd_valid;
    assign dout    = rd_valid ? rdata : '0;

    AST_DRIVE_NEEDS_HELD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> ($past(cs) && $past(oe) && !$past(we) && $past(addr) == addr)); // R4
    AST_NO_DRIVE_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !main_ok); // R10
endmodule

// File: tb/sig_region_tb.sv
module sig_region_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_req = 1'b0;
    logic [12:0] addr = '0;
    logic        cs = 1'b0, oe = 1'b0, we = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, main_ok, tim_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_region dut_i (
        .clk(clk), .rst_n(rst_n), .sig_req(sig_req), .addr(addr),
        .cs(cs), .oe(oe), .we(we), .din(din),
        .dout(dout), .dout_en(dout_en), .main_ok(main_ok), .tim_err(tim_err)
    );

    // Scatter a 6-bit index onto the address, other bits from junk.
    function automatic logic [12:0] map(input logic [5:0] i, input logic [12:0] junk);
        logic [12:0] a;
        a = junk & ~13'b1_1100_0111_0000;
        a[6] = i[5]; a[5] = i[4]; a[4] = i[3];
        a[12] = i[2]; a[11] = i[1]; a[10] = i[0];
        return a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs = 1'b0; oe = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sig_req = 1'b0; idle(); addr = '0;
        repeat (3) @(negedge clk);
        chk("R11 dout_en in reset", dout_en, 0);
        chk("R11 main_ok in reset", main_ok, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enter();
        sig_req = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input logic [5:0] i, input logic [12:0] junk,
                           input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = map(i, junk); cs = 1'b1; oe = 1'b1; we = 1'b0;
        repeat (4) @(negedge clk);
        chk({tag, " dout_en"}, dout_en, 1);
        chk({tag, " data"}, dout, exp);
        idle();
    endtask

    task automatic do_write(input logic [5:0] i, input logic [12:0] junk, input logic [7:0] d,
                            input int setup, input int width);
        @(negedge clk);
        addr = map(i, junk); cs = 1'b1; oe = 1'b0; we = 1'b0; din = d;
        repeat (setup) @(negedge clk);
        we = 1'b1;
        repeat (width) @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 dout_en after reset", dout_en, 0);
        chk("R11 main_ok after reset", main_ok, 1);
        chk("R11 tim_err after reset", tim_err, 0);
    endtask

    task automatic t_entry();
        do_reset();
        sig_req = 1'b1; addr = map(6'd0, 13'h0); cs = 1'b1; oe = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 read before entry not counted", dout_en, 0);
        @(negedge clk);
        chk("R9 read valid one edge later", dout_en, 1);
        chk("R9 main_ok low in mode", main_ok, 0);
        idle();
    endtask

    task automatic t_ids();
        do_read(6'd0, 13'h0A8F, 8'h34, "R2 maker code, R1 junk bits");
        do_read(6'd1, 13'h038F, 8'h41, "R2 part code");
    endtask

    task automatic t_blank();
        do_read(6'd2, 13'h0, 8'hFF, "R3 index 2 blank");
        do_read(6'd63, 13'h0, 8'hFF, "R3 index 63 blank");
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = map(6'd9, 13'h0); cs = 1'b1; oe = 1'b1; we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 off after 3 edges", dout_en, 0);
        @(negedge clk);
        chk("R4 on after 4 edges", dout_en, 1);
        addr = map(6'd10, 13'h0);
        #1 chk("R4 off at address change", dout_en, 0);
        repeat (3) @(negedge clk);
        chk("R4 off 3 edges after change", dout_en, 0);
        @(negedge clk);
        chk("R4 on 4 edges after change", dout_en, 1);
        oe = 1'b0;
        #1 chk("R10 off when oe low", dout_en, 0);
        oe = 1'b1; cs = 1'b0;
        #1 chk("R10 off when cs low", dout_en, 0);
        idle();
    endtask

    task automatic t_write();
        do_write(6'h2A, 13'h0, 8'h5A, 2, 4);
        chk("R6 no error at exact setup", tim_err, 0);
        do_read(6'h2A, 13'h028F, 8'h5A, "R5 readback, R1 other junk");
        do_write(6'h15, 13'h0, 8'hC3, 2, 4);
        do_read(6'h15, 13'h0, 8'hC3, "R5 second byte");
        do_read(6'h2A, 13'h0, 8'h5A, "R5 first byte kept");
    endtask

    task automatic t_id_protect();
        do_write(6'd0, 13'h0, 8'h00, 2, 4);
        do_write(6'd1, 13'h0, 8'h99, 2, 4);
        do_read(6'd0, 13'h0, 8'h34, "R8 maker code kept");
        do_read(6'd1, 13'h0, 8'h41, "R8 part code kept");
        chk("R8 no error on code write", tim_err, 0);
    endtask

    task automatic t_setup();
        do_reset();
        enter();
        do_write(6'h30, 13'h0, 8'h77, 1, 4);
        chk("R6 error on short setup", tim_err, 1);
        do_read(6'h30, 13'h0, 8'hFF, "R6 write discarded");
        chk("R6 error stays set", tim_err, 1);
    endtask

    task automatic t_short();
        do_reset();
        enter();
        do_write(6'h31, 13'h0, 8'h66, 2, 3);
        chk("R7 error on short window", tim_err, 1);
        do_read(6'h31, 13'h0, 8'hFF, "R7 write discarded");
    endtask

    task automatic t_exit();
        @(negedge clk);
        addr = map(6'd0, 13'h0); cs = 1'b1; oe = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 read on before exit", dout_en, 1);
        sig_req = 1'b0;
        #1 chk("R10 off when flag drops", dout_en, 0);
        @(negedge clk);
        sig_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 main_ok low after 3 edges", main_ok, 0);
        chk("R9 no drive during exit", dout_en, 0);
        @(negedge clk);
        chk("R9 main_ok high after 4 edges", main_ok, 1);
        @(negedge clk);
        chk("R9 re-entry only after exit", main_ok, 0);
        sig_req = 1'b0;
        idle();
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_entry();
        t_ids();
        t_blank();
        t_latency();
        t_write();
        t_id_protect();
        t_exit();
        t_setup();
        t_short();
        finish_run();
    end
endmodule